// File: doc/BRIEF.md
# Interrupt Acknowledge and Priority Stack

This block sits between the arbitration logic of a priority interrupt controller and one processor. Arbitration hands it the winning request as a valid flag, a vector number and a priority level. The block raises the request line to the processor while that priority is strictly above the current priority. Software reads a memory-mapped acknowledge word, which joins a vector table base with the latched vector number so that it can index a table of handler addresses.

In software vector mode, the acknowledge read takes effect. It saves the current priority on a last-in-first-out stack and raises the current priority to the level of the acknowledged request, which masks that request. An end-of-interrupt write restores the saved level. In hardware vector mode, the same read only returns data. A configuration input selects 4-byte or 8-byte table entries. Software can also write the current priority directly. A push onto a full stack or a pop from an empty stack is dropped and sets a sticky error output.

Top module: `irq_ack_unit`

## Requirements
- R1: `irq_o` is 1 exactly when `pend_valid` is 1 and `pend_prio` is strictly greater than the current priority. Priorities run from 0 to 15.
- R2: In software vector mode (`hw_vec_mode`=0), an acknowledge read (`rd_en`=1, `wr_en`=0, `reg_sel`=0) deasserts `irq_o` from the next cycle while the same request stays pending.
- R3: A software-mode acknowledge read pushes the current priority onto the stack. It then loads the current priority with the priority latched with the vector. The latched priority resets to 0.
- R4: The side effects of an acknowledge read are the same for every `rd_size` value (0 byte, 1 halfword, 2 word).
- R5: In hardware vector mode, an acknowledge read changes neither the current priority nor the stack nor `irq_o`.
- R6: The vector and priority are captured on every clock edge at which `irq_o` is 1, in either mode. When `irq_o` is 0 they hold their values.
- R7: With `wide_entry`=0, the acknowledge word is base[31:11], then the vector in bits 10:2, then 00 in bits 1:0. With `wide_entry`=1, it is base[31:12], then the vector in bits 11:3, then 000 in bits 2:0. A write to `reg_sel`=0 sets the base from `wr_data`[31:11].
- R8: A write to `reg_sel`=2 (end of interrupt) pops the top of the stack into the current priority. Values come back in last-in-first-out order.
- R9: The stack holds 14 entries. A push when full or a pop when empty leaves the stack and the popped-into priority unchanged and sets `stk_err_o`, which stays set until reset.
- R10: A write to `reg_sel`=1 loads the current priority from `wr_data`[3:0]. A read of `reg_sel`=1 returns it zero-extended. After reset the current priority is 15, the stack is empty and `stk_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_vec_mode | input | 1 | 1 selects hardware vector mode, 0 software vector mode |
| wide_entry | input | 1 | 1 selects 8-byte vector table entries, 0 selects 4-byte entries |
| pend_valid | input | 1 | Arbitration winner is present |
| pend_vec | input | 9 | Vector number of the winner |
| pend_prio | input | 4 | Priority of the winner |
| irq_o | output | 1 | Interrupt request to the processor |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 acknowledge/base, 1 current priority, 2 end of interrupt |
| rd_size | input | 2 | Access size of the read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational from the selected register |
| stk_err_o | output | 1 | Sticky stack overflow/underflow flag |

## Verification
A table of patterns pairs current priorities with pending priorities that are below, equal to and above them, with the valid flag both set and clear. These patterns separate a strict comparison from a non-strict one and show that an invalid winner is ignored. The same table alternates the entry-size bit, which exposes a shifted vector or a wrongly truncated base. It runs in hardware vector mode, so the vector field must follow only the patterns that raised the request. A nested acknowledge and restore sequence and a fill-to-overflow sequence with mixed access sizes then check the last-in-first-out order and the error flag. A hardware-mode acknowledge shows that the read leaves the priority and the stack untouched.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  typedef enum logic [1:0] {
    SEL_ACK  = 2'd0,
    SEL_CPR  = 2'd1,
    SEL_EOI  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_req_gate.sv
module irq_req_gate #(
  parameter int VEC_W  = 9,
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_valid,
  input  logic [VEC_W-1:0]  pend_vec,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic [PRIO_W-1:0] cur_prio,
  output logic              req_o,
  output logic [VEC_W-1:0]  vec_q,
  output logic [PRIO_W-1:0] prio_q
);
  logic              cap_en;
  logic [VEC_W-1:0]  vec_d;
  logic [PRIO_W-1:0] prio_d;

  always_comb begin
    req_o  = pend_valid && (pend_prio > cur_prio);
    cap_en = req_o;
    vec_d  = vec_q;
    prio_d = prio_q;
    if (cap_en) begin
      vec_d  = pend_vec;
      prio_d = pend_prio;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      prio_q <= '0;
    end else begin
      vec_q  <= vec_d;
      prio_q <= prio_d;
    end
  end

  // Latched vector only moves on cycles with an active request
  assert_vec_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_o |=> $stable(vec_q));
  assert_vec_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> vec_q == $past(pend_vec));
endmodule

// File: rtl/prio_lifo.sv
module prio_lifo #(
  parameter int DEPTH = 14,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top_o,
  output logic         full_o,
  output logic         empty_o,
  output logic         push_drop_o,
  output logic         pop_drop_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;
  logic [AW-1:0] top_idx;

  always_comb begin
    full_o      = (cnt_q == CW'(DEPTH));
    empty_o     = (cnt_q == '0);
    do_push     = push && !full_o;
    do_pop      = pop && !push && !empty_o;
    push_drop_o = push && full_o;
    pop_drop_o  = pop && !push && empty_o;
    top_idx     = empty_o ? '0 : AW'(cnt_q - CW'(1));
    top_o       = empty_o ? '0 : mem[top_idx];
    cnt_d       = cnt_q;
    if (do_push)     cnt_d = cnt_q + CW'(1);
    else if (do_pop) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic wen;
    assign wen = do_push && (cnt_q == CW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[i] <= '0;
      else if (wen) mem[i] <= din;
    end
  end

  assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_full_push_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full_o) |=> $stable(cnt_q));
  assert_empty_pop_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty_o) |=> $stable(cnt_q));
  assert_push_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full_o) |=> cnt_q == $past(cnt_q) + CW'(1));
endmodule

// File: rtl/ack_word_fmt.sv
module ack_word_fmt #(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 9
) (
  input  logic [DATA_W-VEC_W-3:0] base_hi,
  input  logic [VEC_W-1:0]        vec,
  input  logic                    wide,
  output logic [DATA_W-1:0]       word_o
);
  localparam int BASE_W = DATA_W - VEC_W - 2;

  always_comb begin
    if (wide) word_o = {base_hi[BASE_W-1:1], vec, 3'b000};
    else      word_o = {base_hi, vec, 2'b00};
  end
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit #(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 9,
  parameter int PRIO_W = 4,
  parameter int DEPTH  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_vec_mode,
  input  logic              wide_entry,
  input  logic              pend_valid,
  input  logic [VEC_W-1:0]  pend_vec,
  input  logic [PRIO_W-1:0] pend_prio,
  output logic              irq_o,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [1:0]        rd_size,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              stk_err_o
);
  import irq_ack_pkg::*;

  localparam int BASE_W  = DATA_W - VEC_W - 2;
  localparam int BASE_LO = VEC_W + 2;
  localparam logic [PRIO_W-1:0] PRIO_MAX = '1;

  logic [PRIO_W-1:0] cpr_q, cpr_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic              err_q, err_d;
  logic [VEC_W-1:0]  vec_q;
  logic [PRIO_W-1:0] prio_q;
  logic [PRIO_W-1:0] stk_top;
  logic              stk_full, stk_empty, push_drop, pop_drop;
  logic              ack_rd, sw_ack, wr_cpr, wr_eoi, wr_base;
  logic [DATA_W-1:0] ack_word;
  logic [1:0]        size_unused;

  assign size_unused = rd_size;

  irq_req_gate #(.VEC_W(VEC_W), .PRIO_W(PRIO_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .pend_valid(pend_valid), .pend_vec(pend_vec),
    .pend_prio(pend_prio), .cur_prio(cpr_q), .req_o(irq_o),
    .vec_q(vec_q), .prio_q(prio_q)
  );

  prio_lifo #(.DEPTH(DEPTH), .W(PRIO_W)) u_lifo (
    .clk(clk), .rst_n(rst_n), .push(sw_ack), .pop(wr_eoi), .din(cpr_q),
    .top_o(stk_top), .full_o(stk_full), .empty_o(stk_empty),
    .push_drop_o(push_drop), .pop_drop_o(pop_drop)
  );

  ack_word_fmt #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_fmt (
    .base_hi(base_q), .vec(vec_q), .wide(wide_entry), .word_o(ack_word)
  );

  always_comb begin
    ack_rd  = rd_en && !wr_en && (reg_sel == SEL_ACK);
    sw_ack  = ack_rd && !hw_vec_mode;
    wr_cpr  = wr_en && (reg_sel == SEL_CPR);
    wr_eoi  = wr_en && (reg_sel == SEL_EOI);
    wr_base = wr_en && (reg_sel == SEL_ACK);

    cpr_d = cpr_q;
    if (wr_cpr)                   cpr_d = wr_data[PRIO_W-1:0];
    else if (wr_eoi && !stk_empty) cpr_d = stk_top;
    else if (sw_ack)              cpr_d = prio_q;

    base_d = wr_base ? wr_data[DATA_W-1:BASE_LO] : base_q;
    err_d  = err_q || push_drop || pop_drop;

    unique case (reg_sel)
      SEL_ACK: rd_data = ack_word;
      SEL_CPR: rd_data = DATA_W'(cpr_q);
      default: rd_data = '0;
    endcase
    if (!rd_en) rd_data = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpr_q  <= PRIO_MAX;
      base_q <= '0;
      err_q  <= 1'b0;
    end else begin
      cpr_q  <= cpr_d;
      base_q <= base_d;
      err_q  <= err_d;
    end
  end

  assign stk_err_o = err_q;

  assert_ack_loads_prio_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ack |=> cpr_q == $past(prio_q));
  assert_hw_ack_inert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && hw_vec_mode) |=> $stable(cpr_q));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  assert_eoi_empty_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_eoi && stk_empty) |=> $stable(cpr_q));
endmodule

// File: tb/irq_ack_unit_bench.sv
module irq_ack_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hw_vec_mode, wide_entry, pend_valid, rd_en, wr_en;
  logic [8:0]  pend_vec;
  logic [3:0]  pend_prio;
  logic [1:0]  reg_sel, rd_size;
  logic [31:0] wr_data, rd_data;
  logic        irq_o, stk_err_o;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] w;

  always #2 clk = ~clk;

  irq_ack_unit u_irq_ack_unit (
    .clk(clk), .rst_n(rst_n), .hw_vec_mode(hw_vec_mode), .wide_entry(wide_entry),
    .pend_valid(pend_valid), .pend_vec(pend_vec), .pend_prio(pend_prio),
    .irq_o(irq_o), .rd_en(rd_en), .wr_en(wr_en), .reg_sel(reg_sel),
    .rd_size(rd_size), .wr_data(wr_data), .rd_data(rd_data), .stk_err_o(stk_err_o)
  );

  // fields: cpr[19:16] valid[15] prio[14:11] vec[10:2] wide[1] exp_irq[0]
  localparam int NV = 8;
  localparam logic [19:0] TBL [NV] = '{
    {4'd3,  1'b1, 4'd4,  9'h001, 1'b0, 1'b1},
    {4'd4,  1'b1, 4'd4,  9'h0F0, 1'b0, 1'b0},
    {4'd4,  1'b0, 4'd9,  9'h1FF, 1'b1, 1'b0},
    {4'd0,  1'b1, 4'd15, 9'h1FF, 1'b1, 1'b1},
    {4'd14, 1'b1, 4'd15, 9'h0AA, 1'b0, 1'b1},
    {4'd15, 1'b1, 4'd15, 9'h155, 1'b1, 1'b0},
    {4'd7,  1'b1, 4'd2,  9'h123, 1'b1, 1'b0},
    {4'd0,  1'b1, 4'd1,  9'h100, 1'b0, 1'b1}
  };
  localparam logic [31:0] BASE = 32'hABCDEF00;

  function automatic logic [31:0] exp_word(input logic [31:0] b, input logic [8:0] v,
                                           input logic wd);
    if (wd) return (b & 32'hFFFFF000) | (32'(v) << 3);
    else    return (b & 32'hFFFFF800) | (32'(v) << 2);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; hw_vec_mode = 0; wide_entry = 0; pend_valid = 0; pend_vec = 0;
    pend_prio = 0; rd_en = 0; wr_en = 0; reg_sel = 2'd3; rd_size = 2'd2; wr_data = 0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); wr_en = 1; reg_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0; reg_sel = 2'd3;
  endtask

  task automatic ack(input logic [1:0] sz, output logic [31:0] word);
    @(negedge clk); rd_en = 1; reg_sel = 2'd0; rd_size = sz;
    #1 word = rd_data;
    @(negedge clk); rd_en = 0; reg_sel = 2'd3;
  endtask

  task automatic rd_cpr(output logic [31:0] v);
    @(negedge clk); rd_en = 1; reg_sel = 2'd1;
    #1 v = rd_data; rd_en = 0; reg_sel = 2'd3;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [8:0] cur_vec;
    do_reset();
    // R10 reset state
    rd_cpr(w); chk("R10 reset cpr", w, 32'd15);
    chk("R10 reset err", 32'(stk_err_o), 0);
    pend_valid = 1; pend_prio = 4'd15; #1;
    chk("R1 max prio masked at reset", 32'(irq_o), 0);
    pend_valid = 0;

    // Table walk in hardware mode (reads are inert)
    hw_vec_mode = 1;
    wr(2'd0, BASE);
    cur_vec = 9'h0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); pend_valid = 0;
      wr(2'd1, 32'(TBL[i][19:16]));
      @(negedge clk);
      pend_valid = TBL[i][15]; pend_prio = TBL[i][14:11]; pend_vec = TBL[i][10:2];
      wide_entry = TBL[i][1];
      #1 chk("R1 request compare", 32'(irq_o), 32'(TBL[i][0]));
      if (TBL[i][0]) cur_vec = TBL[i][10:2];
      ack(2'd2, w);
      chk("R7/R6 ack word", w, exp_word(BASE, cur_vec, TBL[i][1]));
      rd_cpr(w); chk("R5 cpr unchanged by hw ack", w, 32'(TBL[i][19:16]));
    end

    // R6 hold when request drops
    @(negedge clk); pend_valid = 0; pend_vec = 9'h0EE;
    ack(2'd2, w);
    chk("R6 vector held", w, exp_word(BASE, cur_vec, wide_entry));

    // R5 hw ack does not push: following pop hits empty stack
    pend_valid = 1; pend_prio = 4'd8;
    wr(2'd1, 32'd3);
    ack(2'd2, w);
    #1 chk("R5 irq stays up", 32'(irq_o), 1);
    wr(2'd2, 0);
    chk("R5 stack untouched (pop empty)", 32'(stk_err_o), 1);
    rd_cpr(w); chk("R9 cpr kept on empty pop", w, 32'd3);

    // Software mode nesting
    do_reset();
    wr(2'd1, 32'd2);
    @(negedge clk); pend_valid = 1; pend_prio = 4'd7; pend_vec = 9'h055;
    #1 chk("R1 irq up", 32'(irq_o), 1);
    ack(2'd2, w);
    chk("R7 narrow word zero base", w, 32'h154);
    #1 chk("R2 irq drops after ack", 32'(irq_o), 0);
    rd_cpr(w); chk("R3 cpr raised", w, 32'd7);
    @(negedge clk); pend_prio = 4'd9; pend_vec = 9'h1A3;
    #1 chk("R1 higher prio preempts", 32'(irq_o), 1);
    ack(2'd0, w);
    #1 chk("R2 irq drops after byte ack", 32'(irq_o), 0);
    rd_cpr(w); chk("R4 byte ack raises cpr", w, 32'd9);
    pend_valid = 0;
    wr(2'd2, 0); rd_cpr(w); chk("R8 first pop", w, 32'd7);
    wr(2'd2, 0); rd_cpr(w); chk("R8 second pop", w, 32'd2);
    chk("R9 no error yet", 32'(stk_err_o), 0);
    wr(2'd2, 0); rd_cpr(w); chk("R9 empty pop keeps cpr", w, 32'd2);
    chk("R9 underflow flag", 32'(stk_err_o), 1);

    // Overflow with mixed access sizes
    do_reset();
    for (int i = 0; i < 14; i++) begin
      wr(2'd1, 32'(i));
      ack(2'(i % 3), w);
    end
    chk("R9 fourteen pushes fit", 32'(stk_err_o), 0);
    rd_cpr(w); chk("R3 cpr from latched prio 0", w, 32'd0);
    wr(2'd1, 32'd15);
    ack(2'd1, w);
    chk("R9 overflow flag", 32'(stk_err_o), 1);
    for (int i = 13; i >= 0; i--) begin
      wr(2'd2, 0); rd_cpr(w);
      chk("R8 R4 lifo order", w, 32'(i));
    end
    wr(2'd1, 32'd6);
    wr(2'd2, 0); rd_cpr(w); chk("R9 pop past bottom ignored", w, 32'd6);
    chk("R9 flag sticky", 32'(stk_err_o), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule